// File: doc/BRIEF.md
# Character Display Host Bus Front End

This block is the processor-facing side of a character display controller. A host drives an 8-bit parallel bus with a register-select line, a read/write line and an enable strobe. Each write, taken on the falling edge of the enable strobe, lands either in the command path or in the data path, depending on register select. Commands move the RAM address counter into the character-code RAM or the glyph-pattern RAM, switch the display on or off, or clear the character-code RAM. Data bytes are written at the address counter, which then steps forward. Each accepted operation keeps a busy flag raised for a fixed execution time. The host reads that flag, together with the address counter, from a status read.

The character RAMs live outside the block. They are reached through a single port that a display refresh reader also uses. Refresh always wins that port. A host write waits for a free cycle, and busy stays raised until the write has gone out. The display on/off command also sends a one-cycle pulse that restarts the refresh row counter.

Top module: `lcd_host_if`

## Requirements
- R1: A write with register select 0 is decoded as a command. A write with register select 1 is stored as a data byte and sent to the RAM port at the current address counter, with the RAM select taken from the last address command.
- R2: When there is no refresh contention, busy is high for exactly EXEC_CYCLES clocks after the clock edge that accepts a command or data write.
- R3: A write whose enable falls while busy is high is dropped. It causes no RAM write, no change to the address counter and no command action.
- R4: After each data write, the address counter increments. It wraps from 0x7F to 0x00 in character-code mode, and within six bits (0x3F to 0x00) in glyph mode.
- R5: Command byte 1aaaaaaa sets the address counter to aaaaaaa and selects the character-code RAM. Command byte 01aaaaaa sets it to aaaaaa and selects the glyph RAM (ram_cg = 1).
- R6: Command byte 00001dxx sets disp_on to d and raises row_reset for exactly one clock.
- R7: Command byte 0x01 writes the fill code 0x20 to character-code addresses 0 through CLR_DEPTH-1 in ascending order. It also sets the address counter to 0 and selects the character-code RAM. Busy stays high until the last fill write is done.
- R8: While refresh_req is high, ram_we is low and ram_addr and ram_cg follow refresh_addr and refresh_cg. A pending host write waits, and busy stays high until the write is performed.
- R9: While the enable is high with read/write 1 and register select 0, bus_dout is {busy, address counter[6:0]}. A read with register select 1 returns 0. Reads never start busy.
- R10: After reset, busy is 0, the address counter is 0, disp_on is 0, and no RAM write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Enable strobe; writes are taken on its falling edge |
| bus_din | input | 8 | Host write byte |
| bus_dout | output | 8 | Host read byte |
| refresh_req | input | 1 | Refresh reader claims the RAM port this cycle |
| refresh_addr | input | 7 | Refresh read address |
| refresh_cg | input | 1 | Refresh reads the glyph RAM |
| ram_we | output | 1 | RAM write strobe |
| ram_cg | output | 1 | RAM select: 1 glyph RAM, 0 character-code RAM |
| ram_addr | output | 7 | Shared RAM address |
| ram_wdata | output | 8 | RAM write byte |
| disp_on | output | 1 | Display enable state |
| row_reset | output | 1 | One-cycle pulse that restarts the refresh row counter |

## Verification
The hardest case to reach from the ports is a host write held back by the refresh reader, with busy outlasting the execution timer. It is also hard to show that the write still lands at the right address once the port frees up. The stimulus holds refresh_req high for far longer than the execution time, polls the status read during that period, and then releases the port. The clear command is then run under a refresh request that toggles every cycle, so each fill write must find a free slot without losing or reordering addresses. A scoreboard queue holds every RAM write the requirements predict, and compares it against the writes seen at the port.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int ADDR_W = 7;   // fixed by the 7-bit address field of the command byte
  localparam int CG_W   = 6;   // glyph RAM address width
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE, OP_SET_DD, OP_SET_CG, OP_DISP, OP_CLEAR
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic              disp;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_t c;
    c.op   = OP_NONE;
    c.addr = '0;
    c.disp = 1'b0;
    if (b[7]) begin
      c.op   = OP_SET_DD;
      c.addr = b[ADDR_W-1:0];
    end else if (b[6]) begin
      c.op   = OP_SET_CG;
      c.addr = {{(ADDR_W-CG_W){1'b0}}, b[CG_W-1:0]};
    end else if (b[7:3] == 5'b00001) begin
      c.op   = OP_DISP;
      c.disp = b[2];
    end else if (b == 8'h01) begin
      c.op = OP_CLEAR;
    end
    return c;
  endfunction
endpackage

// File: rtl/lcd_bus_capture.sv
module lcd_bus_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en,
  input  logic bus_rw,
  input  logic bus_rs,
  input  logic busy,
  output logic fall,
  output logic instr_go,
  output logic data_go
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= bus_en;
  end

  always_comb begin
    fall     = en_q & ~bus_en;
    instr_go = fall & ~bus_rw & ~busy & ~bus_rs;
    data_go  = fall & ~bus_rw & ~busy &  bus_rs;
  end
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int EXEC_CYCLES = 10,
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start | (cnt != '0);
    cnt_d  = start ? CNT_W'(EXEC_CYCLES) : cnt - 1'b1;
    active = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/lcd_ram_arbiter.sv
module lcd_ram_arbiter
  import lcd_host_pkg::*;
(
  input  logic              refresh_req,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic              refresh_cg,
  input  logic              pend,
  input  logic [BYTE_W-1:0] pend_data,
  input  logic [ADDR_W-1:0] ac,
  input  logic              ac_cg,
  input  logic              clr,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic [BYTE_W-1:0] fill_code,
  output logic              ram_we,
  output logic              ram_cg,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              host_grant
);
  always_comb begin
    host_grant = ~refresh_req & (pend | clr);
    ram_we     = host_grant;
    ram_cg     = refresh_cg;
    ram_addr   = refresh_addr;
    ram_wdata  = '0;
    if (host_grant && pend) begin
      ram_cg    = ac_cg;
      ram_addr  = ac;
      ram_wdata = pend_data;
    end else if (host_grant) begin
      ram_cg    = 1'b0;
      ram_addr  = clr_addr;
      ram_wdata = fill_code;
    end
  end
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_host_pkg::*;
#(
  parameter int                EXEC_CYCLES = 10,
  parameter int                CLR_DEPTH   = 128,
  parameter logic [BYTE_W-1:0] FILL_CODE   = 8'h20,
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1),
  localparam logic [ADDR_W-1:0] CLR_LAST = ADDR_W'(CLR_DEPTH - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic              bus_en,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  input  logic              refresh_req,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic              refresh_cg,
  output logic              ram_we,
  output logic              ram_cg,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              disp_on,
  output logic              row_reset
);
  logic              fall, instr_go, data_go, busy, timer_active, host_grant;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ac_q, ac_d, ac_inc, caddr_q, caddr_d;
  logic [CG_W-1:0]   cg_next;
  logic              cg_q, cg_d, pend_q, pend_d, clr_q, clr_d;
  logic              disp_q, disp_d, rowrst_q, rowrst_d;
  logic [BYTE_W-1:0] pdata_q, pdata_d;
  cmd_t              cmd;

  lcd_bus_capture u_cap (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rw(bus_rw), .bus_rs(bus_rs),
    .busy(busy), .fall(fall), .instr_go(instr_go), .data_go(data_go)
  );

  lcd_busy_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(instr_go | data_go), .cnt(cnt_q), .active(timer_active)
  );

  lcd_ram_arbiter u_arb (
    .refresh_req(refresh_req), .refresh_addr(refresh_addr), .refresh_cg(refresh_cg),
    .pend(pend_q), .pend_data(pdata_q), .ac(ac_q), .ac_cg(cg_q),
    .clr(clr_q), .clr_addr(caddr_q), .fill_code(FILL_CODE),
    .ram_we(ram_we), .ram_cg(ram_cg), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .host_grant(host_grant)
  );

  assign busy = timer_active | pend_q | clr_q;

  always_comb begin
    cmd     = decode_cmd(bus_din);
    cg_next = ac_q[CG_W-1:0] + 1'b1;
    ac_inc  = cg_q ? ADDR_W'(cg_next) : ac_q + 1'b1;
    ac_d     = ac_q;
    cg_d     = cg_q;
    pend_d   = pend_q;
    pdata_d  = pdata_q;
    clr_d    = clr_q;
    caddr_d  = caddr_q;
    disp_d   = disp_q;
    rowrst_d = 1'b0;
    if (host_grant && pend_q) begin
      pend_d = 1'b0;
      ac_d   = ac_inc;
    end else if (host_grant) begin
      caddr_d = caddr_q + 1'b1;
      if (caddr_q == CLR_LAST) clr_d = 1'b0;
    end
    if (data_go) begin
      pend_d  = 1'b1;
      pdata_d = bus_din;
    end
    if (instr_go) begin
      case (cmd.op)
        OP_SET_DD: begin ac_d = cmd.addr; cg_d = 1'b0; end
        OP_SET_CG: begin ac_d = cmd.addr; cg_d = 1'b1; end
        OP_DISP:   begin disp_d = cmd.disp; rowrst_d = 1'b1; end
        OP_CLEAR:  begin clr_d = 1'b1; caddr_d = '0; ac_d = '0; cg_d = 1'b0; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q     <= '0;
      cg_q     <= 1'b0;
      pend_q   <= 1'b0;
      pdata_q  <= '0;
      clr_q    <= 1'b0;
      caddr_q  <= '0;
      disp_q   <= 1'b0;
      rowrst_q <= 1'b0;
    end else begin
      ac_q     <= ac_d;
      cg_q     <= cg_d;
      pend_q   <= pend_d;
      clr_q    <= clr_d;
      caddr_q  <= caddr_d;
      disp_q   <= disp_d;
      rowrst_q <= rowrst_d;
      if (data_go) pdata_q <= pdata_d;
    end
  end

  always_comb begin
    bus_dout = '0;
    if (bus_en && bus_rw && !bus_rs) bus_dout = {busy, ac_q};
  end

  assign disp_on   = disp_q;
  assign row_reset = rowrst_q;
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk
  import lcd_host_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh_req,
  input logic              ram_we,
  input logic              row_reset,
  input logic              busy,
  input logic              pend_q,
  input logic              cg_q,
  input logic [ADDR_W-1:0] ac_q,
  input logic              fall,
  input logic              bus_rw,
  input logic [CNT_W-1:0]  cnt_q
);
  a_r8_refresh_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> !ram_we);

  a_r10_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_we);

  a_r6_row_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    row_reset |=> !row_reset);

  a_r4_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && pend_q) |=> ac_q == ($past(cg_q)
      ? {1'b0, $past(ac_q[CG_W-1:0]) + 6'd1}
      : $past(ac_q) + 7'd1));

  a_r3_no_reload_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fall && !bus_rw && cnt_q > 1) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r8_busy_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy);
endmodule

bind lcd_host_if lcd_host_if_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .ram_we(ram_we),
  .row_reset(row_reset), .busy(busy), .pend_q(pend_q), .cg_q(cg_q), .ac_q(ac_q),
  .fall(fall), .bus_rw(bus_rw), .cnt_q(cnt_q)
);

// File: tb/tb_lcd_host_if.sv
module tb_lcd_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic       refresh_req = 1'b0;
  logic [6:0] refresh_addr = 7'h00;
  logic       refresh_cg = 1'b0;
  logic       ram_we, ram_cg, disp_on, row_reset;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;

  int checks = 0, failures = 0;
  int mon_checks = 0, mon_fails = 0, row_cnt = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  lcd_host_if dut (
    .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en),
    .bus_din(bus_din), .bus_dout(bus_dout), .refresh_req(refresh_req),
    .refresh_addr(refresh_addr), .refresh_cg(refresh_cg), .ram_we(ram_we),
    .ram_cg(ram_cg), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .disp_on(disp_on), .row_reset(row_reset)
  );

  // monitor: pops predicted RAM writes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (row_reset) row_cnt++;
      if (ram_we && refresh_req) begin
        mon_checks++; mon_fails++;
        $display("FAIL R8 write during refresh act=%h exp=none", ram_addr);
      end
      if (ram_we) begin
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R3 unexpected write act=%h exp=none", {ram_cg, ram_addr, ram_wdata});
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (e !== {ram_cg, ram_addr, ram_wdata}) begin
            mon_fails++;
            $display("FAIL R1 RAM write act=%h exp=%h", {ram_cg, ram_addr, ram_wdata}, e);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic cg, input logic [6:0] a, input logic [7:0] d);
    exp_q.push_back({cg, a, d});
  endtask

  task automatic bus_write(input logic rs, input logic [7:0] d);
    @(negedge clk); bus_rs = rs; bus_rw = 1'b0; bus_din = d; bus_en = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic rs, output logic [7:0] v);
    @(negedge clk); bus_rs = rs; bus_rw = 1'b1; bus_en = 1'b1;
    @(negedge clk); #1 v = bus_dout; bus_en = 1'b0;
    @(negedge clk); bus_rw = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      bus_read(1'b0, v);
      if (!v[7]) return;
    end
  endtask

  task automatic status_is(input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_read(1'b0, v);
    check(v === exp, req, v, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fails + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    status_is(8'h00, "R10 status after reset");
    check(disp_on === 1'b0, "R10 disp_on after reset", disp_on, 0);

    // R5 / R2: set character address 0x40, time busy via continuous status read
    bus_write(1'b0, 8'hC0);
    bus_rs = 1'b0; bus_rw = 1'b1; bus_en = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      #1 if (bus_dout[7]) n++;
      @(negedge clk);
    end
    bus_en = 1'b0; @(negedge clk); bus_rw = 1'b0;
    check(n == 10, "R2 busy cycles", n, 10);
    status_is(8'h40, "R5 set character address");

    // R1 / R4 data burst
    expect_wr(1'b0, 7'h40, 8'h41); bus_write(1'b1, 8'h41); wait_idle();
    expect_wr(1'b0, 7'h41, 8'h42); bus_write(1'b1, 8'h42); wait_idle();
    expect_wr(1'b0, 7'h42, 8'h43); bus_write(1'b1, 8'h43); wait_idle();
    status_is(8'h43, "R4 counter after burst");

    // R3 write while busy dropped (data then data)
    expect_wr(1'b0, 7'h43, 8'h58);
    bus_write(1'b1, 8'h58); bus_write(1'b1, 8'h59); wait_idle();
    status_is(8'h44, "R3 second data write dropped");
    // R3 command while busy dropped
    expect_wr(1'b0, 7'h44, 8'h5A);
    bus_write(1'b1, 8'h5A); bus_write(1'b0, 8'h90); wait_idle();
    status_is(8'h45, "R3 address command dropped");

    // R5 / R4 glyph address and six-bit wrap
    bus_write(1'b0, 8'h7E); wait_idle();
    status_is(8'h3E, "R5 set glyph address");
    expect_wr(1'b1, 7'h3E, 8'h11); bus_write(1'b1, 8'h11); wait_idle();
    expect_wr(1'b1, 7'h3F, 8'h12); bus_write(1'b1, 8'h12); wait_idle();
    expect_wr(1'b1, 7'h00, 8'h13); bus_write(1'b1, 8'h13); wait_idle();
    status_is(8'h01, "R4 glyph wrap");

    // R4 character wrap
    bus_write(1'b0, 8'hFF); wait_idle();
    expect_wr(1'b0, 7'h7F, 8'h77); bus_write(1'b1, 8'h77); wait_idle();
    status_is(8'h00, "R4 character wrap");

    // R6 display on/off
    n = row_cnt;
    bus_write(1'b0, 8'h0C); wait_idle();
    check(disp_on === 1'b1, "R6 display on", disp_on, 1);
    check(row_cnt == n + 1, "R6 row reset pulse", row_cnt, n + 1);
    bus_write(1'b0, 8'h08); wait_idle();
    check(disp_on === 1'b0, "R6 display off", disp_on, 0);
    check(row_cnt == n + 2, "R6 second row pulse", row_cnt, n + 2);

    // R8 refresh holds a pending write
    bus_write(1'b0, 8'hA0); wait_idle();
    @(negedge clk); refresh_req = 1'b1; refresh_addr = 7'h15; refresh_cg = 1'b1;
    expect_wr(1'b0, 7'h20, 8'h52); bus_write(1'b1, 8'h52);
    repeat (25) @(negedge clk);
    #1 check(ram_addr === 7'h15 && ram_cg === 1'b1, "R8 refresh owns port", ram_addr, 7'h15);
    bus_read(1'b0, v);
    check(v === 8'hA0, "R8 busy held while write pending", v, 8'hA0);
    @(negedge clk); refresh_req = 1'b0; refresh_cg = 1'b0;
    wait_idle();
    status_is(8'h21, "R8 held write completed");

    // R7 clear under a toggling refresh request
    for (int i = 0; i < 128; i++) expect_wr(1'b0, 7'(i), 8'h20);
    bus_write(1'b0, 8'h01);
    bus_rs = 1'b0; bus_rw = 1'b1; bus_en = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      refresh_req = ~refresh_req;
      #1 if (!bus_dout[7]) break;
      n++;
      @(negedge clk);
    end
    refresh_req = 1'b0;
    @(negedge clk); bus_en = 1'b0; @(negedge clk); bus_rw = 1'b0;
    check(n >= 128, "R7 busy through clear", n, 128);
    check(exp_q.size() == 0, "R7 all fill writes seen", exp_q.size(), 0);
    status_is(8'h00, "R7 counter after clear");

    // R9 data-register read returns zero and starts nothing
    bus_read(1'b1, v);
    check(v === 8'h00, "R9 data read value", v, 0);
    status_is(8'h00, "R9 read leaves busy low");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
    $finish;
  end
endmodule